// File: doc/BRIEF.md
# Strobe Input Synchronizer and Status Flag

This block takes an asynchronous strobe pin and turns its active edge into one clean pulse that lines up with the internal clock phase. The pin passes through a two-flop synchronizer. Its settled level is compared with the value from the previous cycle. A polarity input chooses whether a rising or a falling transition counts. A detected edge is held pending until the phase qualifier `ph_i` allows it out. It then leaves as a one-cycle pulse.

That pulse does three things in the same cycle:
- It sets a status flag.
- It disarms the automatic flag-clear sequence.
- It raises a terminate request toward the outgoing strobe generator, but only when the current handshake mode permits early termination.

Software clears the flag in two steps: first a status read while the flag is set, then an access to the port data register. An interrupt request reports the flag when its enable input is set. The parameter `ALIGN_MODE` selects how pending edges are released:
- Phase alignment (default) releases on any cycle where the phase qualifier is high.
- Address-strobe alignment releases only in the cycle where the qualifier rises.

Top module: `stb_flag_top`

## Requirements
- R1: The pin is synchronized by two flops. With `edge_pol_i`=1 a 0-to-1 transition is active, with `edge_pol_i`=0 a 1-to-0 transition is active, and the opposite transition produces no pulse.
- R2: In phase alignment with `ph_i` held high, `pulse_o` goes high for exactly one cycle, in the third clock cycle after the pin changes level.
- R3: A cycle with `pulse_o` high makes `flag_o` read 1 from the following cycle on.
- R4: A pulse disarms the clear sequence, so a later data access leaves the flag set unless a fresh status read arms it again.
- R5: `term_o` is high only in cycles where `pulse_o` is high and `term_mode_i` is 1.
- R6: The flag clears in the cycle after a data access (`data_acc_i`), and only if a status read (`stat_rd_i`) was made earlier while the flag was set. A data access without that read leaves the flag at 1.
- R7: If a pulse and the clearing data access fall in the same cycle, the flag stays 1 and the clear sequence is left disarmed.
- R8: `irq_o` equals `flag_o` AND `irq_en_i`.
- R9: In phase alignment, an edge detected while `ph_i` is low is held pending. It is released as a pulse after the first cycle in which `ph_i` is high.
- R10: In address-strobe alignment, a pending edge is released only after a cycle in which `ph_i` is high and was low in the cycle before. While `ph_i` stays steadily high, no pulse is emitted.
- R11: Reset clears the flag, the arming state, the pending edge, the pulse and the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Asynchronous strobe pin |
| edge_pol_i | input | 1 | 1: rising edge active, 0: falling edge active |
| ph_i | input | 1 | Phase qualifier for releasing pulses |
| term_mode_i | input | 1 | Handshake mode allows a pulse to end the output strobe |
| stat_rd_i | input | 1 | Status register read strobe |
| data_acc_i | input | 1 | Port data register access strobe |
| irq_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Strobe status flag |
| pulse_o | output | 1 | Synchronized strobe pulse |
| term_o | output | 1 | Request to end the outgoing strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives the pin with both transition directions under both polarity settings. This shows that only the selected edge produces a pulse. It tries three ways of clearing the flag:
- a data access with no prior status read,
- the proper read-then-access sequence,
- an access that coincides with a new pulse.

Together these separate the arming logic from the set logic. A qualifier held low, a qualifier held high and a qualifier that rises are each applied to both alignment variants. This distinguishes release on a high level from release on a rising qualifier.

// File: rtl/stb_flag_pkg.sv
package stb_flag_pkg;
  localparam int ALIGN_PHASE = 0;
  localparam int ALIGN_ADDR  = 1;
endpackage

// File: rtl/stb_sync.sv
module stb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic edge_pol_i,
  output logic edge_o
);
  localparam int W = STAGES + 1;
  // chain[STAGES-1] is the settled level, chain[STAGES] its previous value
  logic [W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[W-2:0], stb_i};
  end

  logic lvl, prev;
  assign lvl  = chain_q[STAGES-1];
  assign prev = chain_q[STAGES];
  assign edge_o = edge_pol_i ? (lvl & ~prev) : (~lvl & prev);
endmodule

// File: rtl/stb_align.sv
module stb_align
  import stb_flag_pkg::*;
#(
  parameter int ALIGN_MODE = ALIGN_PHASE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic ph_i,
  output logic pulse_o
);
  logic pend_q, pulse_q, rel_ok, want;

  generate
    if (ALIGN_MODE == ALIGN_ADDR) begin : g_addr
      logic ph_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ph_q <= 1'b0;
        else         ph_q <= ph_i;
      end
      assign rel_ok = ph_i & ~ph_q;
      AST_ADDR_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_q |-> ($past(ph_i) && !$past(ph_q))) else $error("ph rise"); // R10
    end else begin : g_phase
      assign rel_ok = ph_i;
      AST_PHASE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_q |-> $past(ph_i)) else $error("ph high"); // R9
    end
  endgenerate

  assign want = pend_q | edge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pend_q  <= want & ~rel_ok;
      pulse_q <= want & rel_ok;
    end
  end

  assign pulse_o = pulse_q;

  AST_PULSE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> ($past(pend_q) || $past(edge_i))) else $error("orphan pulse"); // R2
endmodule

// File: rtl/stb_flag_ctl.sv
module stb_flag_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic stat_rd_i,
  input  logic data_acc_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (pulse_i) begin
      // new strobe wins over a coincident clear and drops the arming
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (stat_rd_i) begin
      armed_q <= flag_q;
    end else if (data_acc_i) begin
      if (armed_q) flag_q <= 1'b0;
      armed_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  AST_PULSE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> flag_q) else $error("flag not set"); // R3
  AST_PULSE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> !armed_q) else $error("still armed"); // R4
  AST_ARM_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(stat_rd_i && flag_q)) else $error("bad arm"); // R6
  AST_CLEAR_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(data_acc_i && armed_q && !pulse_i)) else $error("bad clear"); // R7
endmodule

// File: rtl/stb_flag_top.sv
module stb_flag_top
  import stb_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ALIGN_MODE  = ALIGN_PHASE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic edge_pol_i,
  input  logic ph_i,
  input  logic term_mode_i,
  input  logic stat_rd_i,
  input  logic data_acc_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic pulse_o,
  output logic term_o,
  output logic irq_o
);
  logic edge_w, pulse_w;

  stb_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .stb_i, .edge_pol_i, .edge_o(edge_w)
  );

  stb_align #(.ALIGN_MODE(ALIGN_MODE)) i_align (
    .clk_i, .rst_ni, .edge_i(edge_w), .ph_i, .pulse_o(pulse_w)
  );

  stb_flag_ctl i_flag (
    .clk_i, .rst_ni, .pulse_i(pulse_w), .stat_rd_i, .data_acc_i, .irq_en_i,
    .flag_o, .irq_o
  );

  assign pulse_o = pulse_w;
  assign term_o  = pulse_w & term_mode_i;

  AST_TERM_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> (pulse_o && term_mode_i)) else $error("term"); // R5
endmodule

// File: tb/test_stb_flag_top.sv
module test_stb_flag_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stb = 1'b0, pol = 1'b1, ph = 1'b1, term_mode = 1'b1;
  logic stat_rd = 1'b0, data_acc = 1'b0, irq_en = 1'b0;
  logic flag, pulse, term, irq;
  logic a_flag, a_pulse, a_term, a_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stb_flag_top i_stb_flag_top (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .edge_pol_i(pol), .ph_i(ph),
    .term_mode_i(term_mode), .stat_rd_i(stat_rd), .data_acc_i(data_acc),
    .irq_en_i(irq_en), .flag_o(flag), .pulse_o(pulse), .term_o(term), .irq_o(irq)
  );

  stb_flag_top #(.ALIGN_MODE(1)) i_stb_flag_top_as (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .edge_pol_i(pol), .ph_i(ph),
    .term_mode_i(term_mode), .stat_rd_i(stat_rd), .data_acc_i(data_acc),
    .irq_en_i(irq_en), .flag_o(a_flag), .pulse_o(a_pulse), .term_o(a_term), .irq_o(a_irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  // pin changes now; pulse expected after the third edge
  task automatic fire(input logic lvl, input logic exp_term, input string tag);
    stb = lvl;
    tick(); tick();
    chk(pulse, 1'b0, {tag, " R2 early"});
    tick();
    chk(pulse, 1'b1, {tag, " R2 pulse"});
    chk(term, exp_term, {tag, " R5 term"});
    tick();
    chk(pulse, 1'b0, {tag, " R2 one cycle"});
    chk(flag, 1'b1, {tag, " R3 flag"});
  endtask

  task automatic t_reset();
    chk(flag, 1'b0, "R11 flag"); chk(pulse, 1'b0, "R11 pulse");
    chk(term, 1'b0, "R11 term"); chk(irq, 1'b0, "R11 irq");
  endtask

  task automatic t_rise();
    fire(1'b1, 1'b1, "R1 rising");
    chk(a_pulse, 1'b0, "R10 steady ph");
  endtask

  task automatic t_ignore();
    stb = 1'b0;
    for (int i = 0; i < 5; i++) begin tick(); chk(pulse, 1'b0, "R1 inactive edge"); end
  endtask

  task automatic t_noarm();
    data_acc = 1'b1; tick(); data_acc = 1'b0; tick();
    chk(flag, 1'b1, "R6 access without read");
  endtask

  task automatic t_clear();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    data_acc = 1'b1; tick(); data_acc = 1'b0;
    chk(flag, 1'b0, "R6 read then access");
  endtask

  task automatic t_irq();
    irq_en = 1'b1; #1;
    chk(irq, 1'b0, "R8 flag low");
    term_mode = 1'b0;
    fire(1'b1, 1'b0, "R5 mode off");
    chk(irq, 1'b1, "R8 flag high");
    irq_en = 1'b0; #1;
    chk(irq, 1'b0, "R8 disabled");
    term_mode = 1'b1;
  endtask

  task automatic t_collide();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    pol = 1'b0; stb = 1'b0;
    tick(); tick(); tick();
    chk(pulse, 1'b1, "R1 falling pulse");
    data_acc = 1'b1; tick(); data_acc = 1'b0;
    chk(flag, 1'b1, "R7 collision keeps flag");
    data_acc = 1'b1; tick(); data_acc = 1'b0;
    chk(flag, 1'b1, "R4 disarmed by pulse");
  endtask

  task automatic t_phase();
    pol = 1'b1; ph = 1'b0; tick();
    stb = 1'b1;
    for (int i = 0; i < 5; i++) begin tick(); chk(pulse, 1'b0, "R9 held while low"); end
    ph = 1'b1; tick();
    chk(pulse, 1'b1, "R9 released");
    chk(a_pulse, 1'b1, "R10 released on rise");
    tick();
    chk(pulse, 1'b0, "R9 single");
  endtask

  task automatic t_alt();
    pol = 1'b0; stb = 1'b0;
    for (int i = 0; i < 5; i++) begin tick(); chk(a_pulse, 1'b0, "R10 no rise"); end
    ph = 1'b0; tick();
    chk(a_pulse, 1'b0, "R10 low");
    ph = 1'b1; tick();
    chk(a_pulse, 1'b1, "R10 rise");
    tick();
    chk(a_pulse, 1'b0, "R10 single");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    rst_n = 1'b1;
    tick(); tick();
    t_rise();
    t_ignore();
    t_noarm();
    t_clear();
    t_irq();
    t_collide();
    t_phase();
    t_alt();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule